// File: doc/BRIEF.md
# Average and Absolute-Difference Unit

A 64-bit arithmetic unit with five operations on two source operands. The first is a rounded-up average that keeps the carry out of the operand sum. The second and third give the magnitude of the operand difference, compared as signed or as unsigned numbers. The fourth and fifth add that magnitude to an accumulator value supplied by the caller. The caller holds the accumulator, normally the previous result fed back, so a series of accumulate operations builds a sum of absolute differences.

An operation is launched by raising `start` for one cycle with the opcode and operands valid. The result is captured on the next rising edge, and `done` is high for that one cycle. Starts may come on consecutive cycles. The result holds its value until the next start.

Top module: `avd_unit`

## Requirements
- R1: While `rstN` is low, `result` is zero and `done` is low.
- R2: `done` is high in the cycle after each cycle with `start` high, and low after each cycle without it. `result` updates only on an edge where `start` was high and holds otherwise.
- R3: Opcode 3'b000 gives (srcA + srcB + 1) >> 1 evaluated over 65 bits. Two all-ones operands give all-ones. 0xc523e996a8ff6215 and 0xe1e5b9cc9864c4a8 give 0xd384d1b1a0b2135f.
- R4: Opcode 3'b001 gives |srcA − srcB|, with the larger operand chosen by a two's-complement compare. All-ones and 2 give 3. 0x8000000000000000 and 1 give 0x8000000000000001.
- R5: Opcode 3'b010 gives |srcA − srcB| under an unsigned compare, the same for either operand order. All-ones and 2 give 0xfffffffffffffffd.
- R6: Opcode 3'b011 gives accIn plus the signed-compare magnitude, modulo 2^64.
- R7: Opcode 3'b100 gives accIn plus the unsigned-compare magnitude, modulo 2^64.
- R8: Opcodes 3'b101 to 3'b111 produce a zero result, and `done` still pulses.
- R9: Back-to-back starts each produce their own result one cycle later. Two chained accumulates, each taking the previous result as accIn, sum both magnitudes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Synchronous reset, active low |
| start | input | 1 | Launch strobe for one operation |
| opSel | input | 3 | Operation code |
| srcA | input | 64 | First operand |
| srcB | input | 64 | Second operand |
| accIn | input | 64 | Accumulator value for the accumulate opcodes |
| result | output | 64 | Registered result |
| done | output | 1 | One-cycle pulse marking a new result |

## Verification
The delivery of one result can fall in the same cycle as the launch of the next operation. In that cycle `done` is high and `start` is high again. The bench provokes this by chaining two accumulates on consecutive cycles, feeding the `result` seen in that cycle back as `accIn`. The chain uses the unsigned operands (2, all-ones) then (9, 3) for a wrapped total of 3, and the signed form of the same operands for a total of 9. Both intermediate and final values are compared, which shows that no launch is lost or merged.

// File: rtl/avd_pkg.sv
package avd_pkg;
  typedef enum logic [2:0] {
    OP_AVG  = 3'd0,
    OP_SABS = 3'd1,
    OP_UABS = 3'd2,
    OP_SACC = 3'd3,
    OP_UACC = 3'd4
  } avdOp_e;

  typedef struct packed {
    logic load;
    logic pickAvg;
    logic pickDiff;
    logic addAcc;
    logic signedCmp;
  } avdCtrl_t;
endpackage

// File: rtl/avd_ctrl.sv
module avd_ctrl
  import avd_pkg::*;
(
  input  logic       start,
  input  logic [2:0] opSel,
  output avdCtrl_t   ctrl
);
  always_comb begin
    ctrl = '0;
    ctrl.load = start;
    case (opSel)
      OP_AVG:  ctrl.pickAvg = 1'b1;
      OP_SABS: begin ctrl.pickDiff = 1'b1; ctrl.signedCmp = 1'b1; end
      OP_UABS: ctrl.pickDiff = 1'b1;
      OP_SACC: begin ctrl.pickDiff = 1'b1; ctrl.addAcc = 1'b1; ctrl.signedCmp = 1'b1; end
      OP_UACC: begin ctrl.pickDiff = 1'b1; ctrl.addAcc = 1'b1; end
      default: ;
    endcase
  end
endmodule

// File: rtl/avd_datapath.sv
module avd_datapath
  import avd_pkg::*;
#(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rstN,
  input  avdCtrl_t     ctrl,
  input  logic [W-1:0] srcA,
  input  logic [W-1:0] srcB,
  input  logic [W-1:0] accIn,
  output logic [W-1:0] result,
  output logic         done
);
  localparam int EW = W + 1;

  logic [EW-1:0] sumExt;
  logic          aAbove;
  logic [W-1:0]  magnitude;
  logic [W-1:0]  nextVal;

  assign sumExt = {1'b0, srcA} + {1'b0, srcB} + {{W{1'b0}}, 1'b1};

  always_comb begin
    if (ctrl.signedCmp) aAbove = $signed(srcA) > $signed(srcB);
    else                aAbove = srcA > srcB;
    magnitude = aAbove ? (srcA - srcB) : (srcB - srcA);
    if (ctrl.pickAvg)       nextVal = sumExt[EW-1:1];
    else if (ctrl.pickDiff) nextVal = ctrl.addAcc ? (accIn + magnitude) : magnitude;
    else                    nextVal = '0;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      result <= '0;
      done   <= 1'b0;
    end else begin
      done <= ctrl.load;
      if (ctrl.load) result <= nextVal;
    end
  end
endmodule

// File: rtl/avd_unit.sv
module avd_unit
  import avd_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [2:0]        opSel,
  input  logic [DATA_W-1:0] srcA,
  input  logic [DATA_W-1:0] srcB,
  input  logic [DATA_W-1:0] accIn,
  output logic [DATA_W-1:0] result,
  output logic              done
);
  avdCtrl_t ctrl;

  avd_ctrl u_ctrl (
    .start(start),
    .opSel(opSel),
    .ctrl (ctrl)
  );

  avd_datapath #(.W(DATA_W)) u_dp (
    .clk   (clk),
    .rstN  (rstN),
    .ctrl  (ctrl),
    .srcA  (srcA),
    .srcB  (srcB),
    .accIn (accIn),
    .result(result),
    .done  (done)
  );
endmodule

// File: rtl/avd_unit_chk.sv
module avd_unit_chk #(
  parameter int W = 64
) (
  input logic         clk,
  input logic         rstN,
  input logic         start,
  input logic [2:0]   opSel,
  input logic [W-1:0] srcA,
  input logic [W-1:0] srcB,
  input logic [W-1:0] result,
  input logic         done
);
  logic [W:0]   avgRef;
  logic [W-1:0] udiffRef;
  assign avgRef   = {1'b0, srcA} + {1'b0, srcB} + {{W{1'b0}}, 1'b1};
  assign udiffRef = (srcA > srcB) ? (srcA - srcB) : (srcB - srcA);

  // R1
  reset_clear_chk: assert property (@(posedge clk) !rstN |=> (result == '0 && !done));

  // R2
  done_follows_chk: assert property (@(posedge clk) disable iff (!rstN) start |=> done);

  // R2
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !start |=> (!done && $stable(result)));

  // R3
  avg_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && opSel == 3'd0) |=> result == $past(avgRef[W:1]));

  // R5
  udiff_value_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && opSel == 3'd2) |=> result == $past(udiffRef));

  // R8
  unused_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && opSel > 3'd4) |=> result == '0);
endmodule

bind avd_unit avd_unit_chk #(.W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
  .srcA(srcA), .srcB(srcB), .result(result), .done(done)
);

// File: tb/avd_unit_test.sv
module avd_unit_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [2:0]  opSel = 3'd0;
  logic [63:0] srcA = '0, srcB = '0, accIn = '0;
  logic [63:0] result;
  logic        done;
  int          nRun = 0, nFail = 0;
  bit          finished = 0;

  localparam logic [63:0] ONES = 64'hffffffffffffffff;

  always #10 clk = ~clk;

  avd_unit uut (
    .clk(clk), .rstN(rstN), .start(start), .opSel(opSel),
    .srcA(srcA), .srcB(srcB), .accIn(accIn), .result(result), .done(done)
  );

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Launch at a negedge; returns at the next negedge with the result visible.
  task automatic issue(input logic [2:0] op, input logic [63:0] a, b, acc);
    opSel = op; srcA = a; srcB = b; accIn = acc; start = 1'b1;
    @(negedge clk);
  endtask

  task automatic idle();
    start = 1'b0;
    @(negedge clk);
  endtask

  task automatic runOne(input string req, input logic [2:0] op,
                        input logic [63:0] a, b, acc, exp);
    issue(op, a, b, acc);
    check({req, " done"}, {63'd0, done}, 64'd1);
    check(req, result, exp);
    idle();
  endtask

  task automatic testReset();
    check("R1 result", result, 64'd0);
    check("R1 done", {63'd0, done}, 64'd0);
  endtask

  task automatic testAverage();
    runOne("R3 mixed", 3'd0, 64'hc523e996a8ff6215, 64'he1e5b9cc9864c4a8, '0, 64'hd384d1b1a0b2135f);
    runOne("R3 even", 3'd0, 64'hc523e996a8ff6214, 64'he1e5b9cc9864c4a8, '0, 64'hd384d1b1a0b2135e);
    runOne("R3 odd", 3'd0, 64'hc523e996a8ff6213, 64'he1e5b9cc9864c4a8, '0, 64'hd384d1b1a0b2135e);
    runOne("R3 ones", 3'd0, ONES, ONES, '0, ONES);
  endtask

  task automatic testAbsDiff();
    runOne("R4 small", 3'd1, 64'd1, 64'd2, '0, 64'd1);
    runOne("R4 minus one", 3'd1, ONES, 64'd2, '0, 64'd3);
    runOne("R4 most negative", 3'd1, 64'h8000000000000000, 64'd1, '0, 64'h8000000000000001);
    runOne("R5 small", 3'd2, 64'd1, 64'd2, '0, 64'd1);
    runOne("R5 order ab", 3'd2, ONES, 64'd2, '0, 64'hfffffffffffffffd);
    runOne("R5 order ba", 3'd2, 64'd2, ONES, '0, 64'hfffffffffffffffd);
    runOne("R5 most negative", 3'd2, 64'h8000000000000000, 64'd1, '0, 64'h7fffffffffffffff);
  endtask

  task automatic testAccumulate();
    runOne("R6 single", 3'd3, 64'd2, ONES, 64'd100, 64'd103);
    runOne("R7 single", 3'd4, 64'd9, 64'd3, 64'd10, 64'd16);
    runOne("R7 wrap", 3'd4, 64'd3, 64'd1, ONES, 64'd1);
  endtask

  task automatic testUnused();
    for (int op = 5; op < 8; op++)
      runOne("R8 zero", op[2:0], 64'h1234, 64'h10, 64'h55, 64'd0);
  endtask

  task automatic testHold();
    logic [63:0] held;
    issue(3'd2, 64'd50, 64'd8, '0);
    held = result;
    start = 1'b0; srcA = 64'd999; opSel = 3'd0;
    @(negedge clk);
    check("R2 done low", {63'd0, done}, 64'd0);
    check("R2 hold", result, held);
    @(negedge clk);
    check("R2 hold again", result, 64'd42);
  endtask

  task automatic testChain();
    // R9 unsigned chain: result fed back while the next start is high
    issue(3'd4, 64'd2, ONES, 64'd0);
    check("R9 first", result, 64'hfffffffffffffffd);
    issue(3'd4, 64'd9, 64'd3, result);
    check("R9 done back-to-back", {63'd0, done}, 64'd1);
    check("R9 unsigned total", result, 64'd3);
    // signed chain
    issue(3'd3, 64'd2, ONES, 64'd0);
    check("R9 signed first", result, 64'd3);
    issue(3'd3, 64'd9, 64'd3, result);
    check("R9 signed total", result, 64'd9);
    idle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAverage();
    testAbsDiff();
    testAccumulate();
    testUnused();
    testHold();
    testChain();
    if (!finished) begin
      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nRun++; nFail++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
      $finish;
    end
  end
endmodule